// File: doc/BRIEF.md
# ADC Conversion Sequencer and Output Formatter

This block is the digital side of a pipelined sampling converter. A qualified rising edge on the start input launches a conversion, and the end-of-conversion flag stays high for a fixed number of system-clock cycles. When the conversion completes, the raw code and the out-of-range bit from the analog core are captured. In this project the testbench supplies both in place of the core. Each captured word then moves through a result pipeline, and every word carries its own valid bit.

The word at the end of the pipeline is formatted for the pins. A coding-select input either passes the bits through or complements every data bit, both MSB outputs and the sense of the overflow flag. A second MSB pin always carries the inverse of the first, so a two's-complement code can be assembled from it. The pad driver enable follows an active-low output-enable input. Coding and enable changes are only taken while no conversion is running.

Top module: `adc_seq_top`

## Requirements
- R1: A start is accepted only after start_i has been high for MIN_PULSE (default 4) consecutive clock cycles. A shorter high pulse starts nothing, and eoc_o stays low.
- R2: Each high pulse gives at most one conversion, however long start_i stays high after it has been accepted.
- R3: eoc_o rises in the cycle after a start is accepted. For an uninterrupted conversion it stays high for exactly CONV_CYCLES (default 28) cycles, and it is low while idle.
- R4: raw_data_i and raw_oor_i are captured on the clock edge where eoc_o falls, and the outputs update on that same edge. After conversion k completes, the outputs show the word captured at completion of conversion k-3.
- R5: A start accepted while eoc_o is high restarts the full conversion time. Two words are pushed into the pipeline with data_valid_o = 0: the interrupted conversion's word, at the restart, and the new conversion's word, at its completion.
- R6: With the coding held high, data_o equals the captured code. With it held low, all 16 data bits and the MSB outputs are inverted.
- R7: ovf_o equals the captured out-of-range bit when the coding is high and its inverse when the coding is low.
- R8: msb_o equals data_o[15], and msb_n_o is always its inverse.
- R9: data_oe_o is 1 (pads driven) when the held enable is low, and 0 (pads high-impedance) when it is high.
- R10: code_sel_i and oe_n_i are sampled only on edges where no conversion is running, and they act one cycle later. A change made while eoc_o is high has no effect until the cycle after eoc_o falls.
- R11: After reset: eoc_o = 0, data_valid_o = 0, data_oe_o = 0, coding = pass-through, data_o = 0, msb_n_o = 1 and ovf_o = 0. The first three completed conversions output invalid words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-convert request |
| raw_data_i | input | 16 | Raw code from the analog core |
| raw_oor_i | input | 1 | Out-of-range indication from the analog core |
| code_sel_i | input | 1 | 1 = pass-through coding, 0 = complemented |
| oe_n_i | input | 1 | Output enable, active low |
| eoc_o | output | 1 | High while a conversion runs |
| data_o | output | 16 | Formatted data word |
| msb_o | output | 1 | Formatted MSB |
| msb_n_o | output | 1 | Inverted MSB for two's-complement coding |
| ovf_o | output | 1 | Overflow flag, sense follows the coding |
| data_valid_o | output | 1 | Valid bit of the word on the outputs |
| data_oe_o | output | 1 | Pad driver enable, 0 = high-impedance |

## Verification
A wrong conversion counter shows at eoc_o: the flag falls early or late within the first conversion, and a missed restart leaves it too short after an abort. A wrong pipeline depth or a lost valid bit does not show until three conversions later, when the word on data_o belongs to the wrong conversion or data_valid_o has the wrong value. Coding or enable state that updates during a busy period shows as a change on data_o, ovf_o or data_oe_o while eoc_o is still high, so the bench checks these outputs in the middle of a conversion, just after it ends, and one cycle after that.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned ADC_DW = 16;

  typedef logic [ADC_DW-1:0] adc_word_t;

  typedef struct packed {
    logic      vld;
    logic      oor;
    adc_word_t dat;
  } adc_res_t;
endpackage

// File: rtl/adc_start_filter.sv
module adc_start_filter #(
  parameter int unsigned MIN_PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_PULSE);
  localparam logic [CW-1:0] HIT = CW'(MIN_PULSE - 1);

  logic [CW-1:0] hi_q;

  // counts prior high cycles; saturates so a long level cannot retrigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_q <= '0;
    else if (!start_i)    hi_q <= '0;
    else if (hi_q != SAT) hi_q <= hi_q + 1'b1;
  end

  assign accept_o = start_i && (hi_q == HIT);
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic busy_o,
  output logic done_o,
  output logic abort_o,
  output logic taint_o
);
  localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

  logic          busy_q;
  logic          taint_q;
  logic [CW-1:0] cnt_q;

  assign done_o  = busy_q && (cnt_q == '0) && !accept_i;
  assign abort_o = busy_q && accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      taint_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= LOAD;
      taint_q <= busy_q;  // a restart spoils the new result too
    end else if (done_o) begin
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign taint_o = taint_q;
endmodule

// File: rtl/adc_result_pipe.sv
module adc_result_pipe
  import adc_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  adc_res_t word_i,
  output adc_res_t word_o
);
  // DEPTH latency stages plus the output register
  adc_res_t stg_q [DEPTH+1];

  for (genvar g = 0; g <= DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[g] <= '0;
        else if (push_i) stg_q[g] <= word_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[g] <= '0;
        else if (push_i) stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign word_o = stg_q[DEPTH];
endmodule

// File: rtl/adc_out_format.sv
module adc_out_format
  import adc_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      busy_i,
  input  logic      code_sel_i,
  input  logic      oe_n_i,
  input  adc_res_t  word_i,
  output adc_word_t data_o,
  output logic      msb_o,
  output logic      msb_n_o,
  output logic      ovf_o,
  output logic      data_valid_o,
  output logic      data_oe_o
);
  logic code_q;
  logic oe_n_q;

  // pin settings only move between conversions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else if (!busy_i) begin
      code_q <= code_sel_i;
      oe_n_q <= oe_n_i;
    end
  end

  adc_word_t fmt;
  assign fmt          = code_q ? word_i.dat : ~word_i.dat;
  assign data_o       = fmt;
  assign msb_o        = fmt[ADC_DW-1];
  assign msb_n_o      = ~fmt[ADC_DW-1];
  assign ovf_o        = word_i.oor ^ ~code_q;
  assign data_valid_o = word_i.vld;
  assign data_oe_o    = ~oe_n_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned MIN_PULSE   = 4,
  parameter int unsigned CONV_CYCLES = 28,
  parameter int unsigned PIPE_DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADC_DW-1:0] raw_data_i,
  input  logic              raw_oor_i,
  input  logic              code_sel_i,
  input  logic              oe_n_i,
  output logic              eoc_o,
  output logic [ADC_DW-1:0] data_o,
  output logic              msb_o,
  output logic              msb_n_o,
  output logic              ovf_o,
  output logic              data_valid_o,
  output logic              data_oe_o
);
  logic     accept;
  logic     busy;
  logic     done;
  logic     abort;
  logic     taint;
  logic     push;
  adc_res_t in_word;
  adc_res_t out_word;

  adc_start_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .busy_o  (busy),
    .done_o  (done),
    .abort_o (abort),
    .taint_o (taint)
  );

  // an aborted conversion still occupies one pipeline slot, marked invalid
  assign push = done || abort;
  always_comb begin
    if (abort) begin
      in_word = '0;
    end else begin
      in_word.vld = ~taint;
      in_word.oor = raw_oor_i;
      in_word.dat = raw_data_i;
    end
  end

  adc_result_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .word_i(in_word),
    .word_o(out_word)
  );

  adc_out_format u_fmt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .code_sel_i  (code_sel_i),
    .oe_n_i      (oe_n_i),
    .word_i      (out_word),
    .data_o      (data_o),
    .msb_o       (msb_o),
    .msb_n_o     (msb_n_o),
    .ovf_o       (ovf_o),
    .data_valid_o(data_valid_o),
    .data_oe_o   (data_oe_o)
  );

  assign eoc_o = busy;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned MIN_PULSE   = 4,
  parameter int unsigned CONV_CYCLES = 28
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic oe_n_i,
  input logic eoc_o,
  input logic data_oe_o
);
  localparam int unsigned HW = $clog2(MIN_PULSE + 1);
  localparam int unsigned RW = $clog2(CONV_CYCLES + 1);

  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] run_cnt;
  logic          armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '0;
      run_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (!start_i)                   hi_cnt <= '0;
      else if (hi_cnt != HW'(MIN_PULSE)) hi_cnt <= hi_cnt + 1'b1;
      if (!eoc_o)                     run_cnt <= '0;
      else if (run_cnt != RW'(CONV_CYCLES)) run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1: a conversion only begins after a qualified pulse
  a_r1_start_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> ($past(start_i) && ($past(hi_cnt) >= HW'(MIN_PULSE - 1))));

  // R3: busy never ends before the full conversion time
  a_r3_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_o) |-> (run_cnt >= RW'(CONV_CYCLES)));

  // R9: idle enable sampling reaches the pad enable one cycle later
  a_r9_enable_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(eoc_o)) |-> (data_oe_o == !$past(oe_n_i)));

  // R10: enable is frozen while a conversion runs
  a_r10_enable_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(eoc_o) |-> $stable(data_oe_o));
endmodule

bind adc_seq_top adc_seq_chk #(
  .MIN_PULSE  (MIN_PULSE),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .oe_n_i   (oe_n_i),
  .eoc_o    (eoc_o),
  .data_oe_o(data_oe_o)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  localparam int CONV = 28;
  localparam int NVEC = 8;
  // {raw[15:0], oor, code_sel, oe_n}
  localparam logic [18:0] VEC [NVEC] = '{
    {16'h1234, 1'b0, 1'b1, 1'b0},
    {16'hABCD, 1'b1, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b0, 1'b0},
    {16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h7FFF, 1'b1, 1'b0, 1'b1},
    {16'h5A5A, 1'b0, 1'b1, 1'b0},
    {16'h0001, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start, raw_oor, code_sel, oe_n;
  logic [15:0] raw_data;
  logic eoc_o, msb_o, msb_n_o, ovf_o, data_valid_o, data_oe_o;
  logic [15:0] data_o;

  int checks = 0;
  int fails  = 0;
  logic [17:0] mq [4];  // model pipeline {vld, oor, dat}

  always #2.5 clk = ~clk;

  adc_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .raw_data_i(raw_data),
    .raw_oor_i(raw_oor), .code_sel_i(code_sel), .oe_n_i(oe_n),
    .eoc_o(eoc_o), .data_o(data_o), .msb_o(msb_o), .msb_n_o(msb_n_o),
    .ovf_o(ovf_o), .data_valid_o(data_valid_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic o, input logic [15:0] d);
    for (int j = 3; j > 0; j--) mq[j] = mq[j-1];
    mq[0] = {v, o, d};
  endtask

  function automatic logic [20:0] outs();
    return {data_o, msb_o, msb_n_o, ovf_o, data_valid_o, data_oe_o};
  endfunction

  function automatic logic [20:0] expect_out(input logic c, input logic on);
    logic [15:0] d;
    d = c ? mq[3][15:0] : ~mq[3][15:0];
    return {d, d[15], ~d[15], mq[3][16] ^ ~c, mq[3][17], ~on};
  endfunction

  task automatic check_out(input string req, input logic c, input logic on);
    chk(outs() == expect_out(c, on), req, 32'(outs()), 32'(expect_out(c, on)));
  endtask

  // returns at the first negedge with eoc low; hi = eoc-high samples after start drops
  task automatic do_conv(input logic [15:0] d, input logic o, input int width, output int hi);
    raw_data = d;
    raw_oor  = o;
    start    = 1'b1;
    repeat (width) @(negedge clk);
    start = 1'b0;
    hi = 0;
    while (eoc_o) begin
      hi++;
      @(negedge clk);
    end
    push(1'b1, o, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi;
    logic [20:0] snap;
    bit seen;
    for (int j = 0; j < 4; j++) mq[j] = '0;
    rst_n = 1'b0; start = 1'b0; raw_data = '0; raw_oor = 1'b0;
    code_sel = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state: pass-through, zero word, pads off
    chk(eoc_o == 1'b0, "R11 eoc", 32'(eoc_o), 0);
    chk(outs() == {16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, "R11 outputs",
        32'(outs()), 32'({16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R3 R4 R6 R7 R8 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      code_sel = VEC[i][1];
      oe_n     = VEC[i][0];
      repeat (2) @(negedge clk);
      do_conv(VEC[i][18:3], VEC[i][2], 4, hi);
      chk(hi == CONV, "R3 busy length", 32'(hi), 32'(CONV));
      chk(data_valid_o == mq[3][17], "R4 R11 valid latency", 32'(data_valid_o), 32'(mq[3][17]));
      @(negedge clk);
      check_out("R4 R6 R7 R8 R9 formatted word", VEC[i][1], VEC[i][0]);
    end

    // R1: three-cycle pulse is a glitch
    code_sel = 1'b1; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    snap = outs();
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (eoc_o) seen = 1;
    end
    chk(!seen, "R1 short pulse eoc", 32'(seen), 0);
    chk(outs() == snap, "R1 short pulse outputs", 32'(outs()), 32'(snap));

    // R2: long level gives one conversion
    do_conv(16'hC3C3, 1'b0, 40, hi);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (eoc_o) seen = 1;
    end
    chk(!seen, "R2 no retrigger", 32'(seen), 0);
    check_out("R2 single push", 1'b1, 1'b0);

    // R5: restart during busy
    raw_data = 16'h1111; raw_oor = 1'b0;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(eoc_o == 1'b1, "R5 busy before restart", 32'(eoc_o), 1);
    raw_data = 16'h2222;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    hi = 0;
    while (eoc_o) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == CONV, "R5 restart length", 32'(hi), 32'(CONV));
    push(1'b0, 1'b0, 16'h0000);
    push(1'b0, 1'b0, 16'h2222);
    @(negedge clk);
    check_out("R5 after abort", 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      do_conv(16'h4000 + 16'(k), 1'b0, 4, hi);
      @(negedge clk);
      check_out("R5 invalid pair position", 1'b1, 1'b0);
    end

    // R10: settings changed during busy are held
    code_sel = 1'b1; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    snap = outs();
    raw_data = 16'h00F0; raw_oor = 1'b1;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    code_sel = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(outs() == snap, "R10 held mid conversion", 32'(outs()), 32'(snap));
    while (eoc_o) @(negedge clk);
    push(1'b1, 1'b1, 16'h00F0);
    check_out("R10 old settings at eoc fall", 1'b1, 1'b0);
    @(negedge clk);
    check_out("R10 new settings one cycle later", 1'b0, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule